// File: doc/BRIEF.md
# Shared Prescaler Clock Select

This block produces the count-enable strobes for two timer channels from a single free-running prescaler. A 10-bit counter advances on every system clock. From it, four tap strobes are decoded. Each tap fires for one cycle out of every 8, 64, 256 or 1024 cycles.

Each channel has its own 3-bit select code. The code picks one of five kinds of source for that channel's one-cycle count-enable: no source (the channel is stopped), every system clock, one of the four taps, or an edge strobe that an external pin synchroniser has already produced. Because both channels draw on the same counter, one synchronous prescaler clear moves the tap phase of both channels together. The select codes never touch the counter.

Each count-enable output is registered. It reflects the select code, counter and edge inputs of the previous clock cycle.

Top module: `psc_shared_clksel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter is cleared and both count-enables are 0. After release, a channel on code 2 gives its first strobe in the cycle that follows the 8th rising edge after release.
- R2: Select code 0 keeps the channel's count-enable at 0 in every cycle.
- R3: Select code 1 sets the count-enable to 1 in every cycle, starting one clock edge after the code is applied.
- R4: Codes 2, 3, 4 and 5 select taps of period 8, 64, 256 and 1024. Say the clear is sampled at edge E0. The strobe is then high for exactly one cycle after each edge E0+k where k is a multiple of N, and low after every other edge.
- R5: The counter is never cleared or paused by any select code. Changing one channel's code does not shift the tap phase seen by the other channel.
- R6: A high `presc_clr_i` at a clock edge zeroes the shared counter. This restarts the tap period of both channels at the same edge.
- R7: A channel that switches from code 0 to a tap code of period N gives its first strobe between 1 and N+1 edges later.
- R8: Code 6 copies the channel's falling-edge strobe input to its count-enable one edge later. The rising-edge input has no effect.
- R9: Code 7 copies the channel's rising-edge strobe input to its count-enable one edge later. The falling-edge input has no effect.
- R10: Each channel decodes its own code. Channel 0 uses `sel_i[2:0]` and channel 1 uses `sel_i[5:3]`. Bit i of the edge inputs and of `cnt_en_o` belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_clr_i | input | 1 | Synchronous clear of the shared prescaler counter |
| sel_i | input | 6 | Select codes, 3 bits per channel, channel 0 in the low bits |
| ext_rise_i | input | 2 | Per-channel rising-edge strobe from an external synchroniser |
| ext_fall_i | input | 2 | Per-channel falling-edge strobe from an external synchroniser |
| cnt_en_o | output | 2 | Per-channel one-cycle count-enable strobe |

## Verification
A wrong counter value shows up at the ports as a tap strobe that lands off its expected edge. On the 8-cycle tap this is visible within eight cycles of a clear, but on the 1024-cycle tap it can take a full period. The tests therefore clear the prescaler and then check every cycle over two periods of each tap. A wrong select decode or a stale strobe register shows up one edge after the code or edge input changes, so those cases are checked on the very next cycle. Phase sharing is checked by running both channels on different taps from one clear and checking the cycles where their strobes coincide.

// File: rtl/psc_pkg.sv
// Shared definitions for the prescaler clock-select block.
// Assumes the tap set is fixed at four taps of period 2^3, 2^6, 2^8 and 2^10.
package psc_pkg;

    localparam int SEL_W        = 3;
    localparam int NUM_TAPS     = 4;
    localparam int MAX_TAP_LOG2 = 10;

    // Channel select codes. The numeric values are part of the port contract.
    typedef enum logic [SEL_W-1:0] {
        SEL_STOP     = 3'd0,
        SEL_SYSCLK   = 3'd1,
        SEL_DIV8     = 3'd2,
        SEL_DIV64    = 3'd3,
        SEL_DIV256   = 3'd4,
        SEL_DIV1024  = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } sel_code_e;

    // Log2 of the division ratio of tap number idx (0 is the fastest).
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/psc_counter.sv
// Free-running prescaler counter.
// It advances by one on every clock. A synchronous clear or the active-low
// reset returns it to zero. No channel setting gates it.
module psc_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Count up each cycle; reset and clear both restart from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/psc_tap_decode.sv
// Decodes the tap strobes from the prescaler count.
// Tap i is high while the low tap_log2(i) bits of the count are all ones,
// which happens for one cycle in every 2^tap_log2(i) cycles.
// Assumes CNT_W is at least the widest tap.
module psc_tap_decode
    import psc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [NUM_TAPS-1:0] tap_hit_o
);

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int             TAP_K    = tap_log2(g);
        localparam logic [CNT_W-1:0] TAP_MASK = CNT_W'((1 << TAP_K) - 1);

        // A tap hits when every masked bit of the count is set.
        always_comb begin
            tap_hit_o[g] = ((cnt_i & TAP_MASK) == TAP_MASK);
        end
    end

endmodule

// File: rtl/psc_chan_sel.sv
// Per-channel source selection.
// Chooses the count-enable source from this channel's select code and
// registers it, so the strobe appears one edge after its cause.
// Assumes the edge inputs are already synchronous single-cycle strobes.
module psc_chan_sel
    import psc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_TAPS-1:0] tap_hit_i,
    input  logic                ext_rise_i,
    input  logic                ext_fall_i,
    output logic                en_o
);

    logic en_nxt;

    // Pick the source named by the select code.
    always_comb begin
        case (sel_code_e'(sel_i))
            SEL_STOP:     en_nxt = 1'b0;
            SEL_SYSCLK:   en_nxt = 1'b1;
            SEL_DIV8:     en_nxt = tap_hit_i[0];
            SEL_DIV64:    en_nxt = tap_hit_i[1];
            SEL_DIV256:   en_nxt = tap_hit_i[2];
            SEL_DIV1024:  en_nxt = tap_hit_i[3];
            SEL_EXT_FALL: en_nxt = ext_fall_i;
            SEL_EXT_RISE: en_nxt = ext_rise_i;
            default:      en_nxt = 1'b0;
        endcase
    end

    // Register the selected strobe; reset holds it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b0;
        end else begin
            en_o <= en_nxt;
        end
    end

endmodule

// File: rtl/psc_shared_clksel.sv
// Shared prescaler with per-channel clock select.
// One free-running counter feeds a tap decoder. The tap strobes are shared by
// NCH independent channel selectors. A prescaler clear restarts the tap
// phase for every channel at once.
module psc_shared_clksel
    import psc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = MAX_TAP_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 presc_clr_i,
    input  logic [NCH*SEL_W-1:0] sel_i,
    input  logic [NCH-1:0]       ext_rise_i,
    input  logic [NCH-1:0]       ext_fall_i,
    output logic [NCH-1:0]       cnt_en_o
);

    logic [CNT_W-1:0]    presc_cnt;
    logic [NUM_TAPS-1:0] tap_hit;

    psc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (presc_clr_i),
        .cnt_o (presc_cnt)
    );

    psc_tap_decode #(.CNT_W(CNT_W)) u_taps (
        .cnt_i     (presc_cnt),
        .tap_hit_o (tap_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        psc_chan_sel u_sel (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (sel_i[c*SEL_W +: SEL_W]),
            .tap_hit_i  (tap_hit),
            .ext_rise_i (ext_rise_i[c]),
            .ext_fall_i (ext_fall_i[c]),
            .en_o       (cnt_en_o[c])
        );
    end

endmodule

// File: rtl/psc_shared_clksel_chk.sv
// Assertion checker for psc_shared_clksel, attached by bind.
// It watches the ports and the shared counter and checks them against the
// requirements, one cycle after the cause.
module psc_shared_clksel_chk
    import psc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = MAX_TAP_LOG2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 presc_clr_i,
    input logic [NCH*SEL_W-1:0] sel_i,
    input logic [NCH-1:0]       ext_rise_i,
    input logic [NCH-1:0]       ext_fall_i,
    input logic [NCH-1:0]       cnt_en_o,
    input logic [CNT_W-1:0]     presc_cnt
);

    logic seen;

    // Marks that one full cycle out of reset has elapsed, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    function automatic logic tap_ok(input logic [CNT_W-1:0] c, input logic [SEL_W-1:0] s);
        int k;
        logic [CNT_W-1:0] m;
        k = tap_log2(int'(s) - 2);
        m = CNT_W'((1 << k) - 1);
        return (c & m) == m;
    endfunction

    // R6: a clear zeroes the shared counter at the next edge.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(presc_clr_i) |-> presc_cnt == '0);

    // R5: without a clear the counter always advances, whatever the codes.
    assert_free_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(presc_clr_i) |-> presc_cnt == $past(presc_cnt) + CNT_W'(1));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2: code 0 never strobes.
        assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(sel_i[c*SEL_W +: SEL_W]) == 3'd0 |-> !cnt_en_o[c]);

        // R3: code 1 strobes every cycle.
        assert_sysclk_every_R3: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(sel_i[c*SEL_W +: SEL_W]) == 3'd1 |-> cnt_en_o[c]);

        // R4: a tap strobe only follows a count whose masked bits are all set.
        assert_tap_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
            seen && cnt_en_o[c] && $past(sel_i[c*SEL_W +: SEL_W]) >= 3'd2
                 && $past(sel_i[c*SEL_W +: SEL_W]) <= 3'd5
            |-> tap_ok($past(presc_cnt), $past(sel_i[c*SEL_W +: SEL_W])));

        // R8: code 6 follows the falling-edge strobe.
        assert_ext_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(sel_i[c*SEL_W +: SEL_W]) == 3'd6 |-> cnt_en_o[c] == $past(ext_fall_i[c]));

        // R9: code 7 follows the rising-edge strobe.
        assert_ext_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            seen && $past(sel_i[c*SEL_W +: SEL_W]) == 3'd7 |-> cnt_en_o[c] == $past(ext_rise_i[c]));
    end

endmodule

bind psc_shared_clksel psc_shared_clksel_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_clr_i (presc_clr_i),
    .sel_i       (sel_i),
    .ext_rise_i  (ext_rise_i),
    .ext_fall_i  (ext_fall_i),
    .cnt_en_o    (cnt_en_o),
    .presc_cnt   (presc_cnt)
);

// File: tb/psc_shared_clksel_tb.sv
// Directed bench for psc_shared_clksel: one task per scenario.
// Inputs are driven and outputs sampled on the falling clock edge.
module psc_shared_clksel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [2:0] sel0 = 3'd1;
    logic [2:0] sel1 = 3'd2;
    logic [1:0] rise = 2'b00;
    logic [1:0] fall = 2'b00;
    logic [1:0] en;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #2 clk = ~clk;

    psc_shared_clksel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .presc_clr_i (clr),
        .sel_i       ({sel1, sel0}),
        .ext_rise_i  (rise),
        .ext_fall_i  (fall),
        .cnt_en_o    (en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Pulse the prescaler clear over one rising edge; return on the next falling edge.
    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic t_reset_R1();
        repeat (3) @(negedge clk);
        check("R1 reset ch0", en[0], 1'b0);
        check("R1 reset ch1", en[1], 1'b0);
        rst_n = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            check("R1 ch1 first tap", en[1], (k % 8) == 0);
        end
    endtask

    task automatic t_stop_sysclk_R2_R3();
        @(negedge clk) begin sel0 = 3'd1; sel1 = 3'd0; end
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check("R3 code1 every cycle", en[0], 1'b1);
            if (k >= 2) check("R2 R10 code0 quiet", en[1], 1'b0);
        end
    endtask

    task automatic t_tap_R4(input logic [2:0] code, input int n);
        @(negedge clk) begin sel0 = code; sel1 = 3'd0; end
        pulse_clr();
        for (int k = 1; k <= 2 * n; k++) begin
            @(negedge clk);
            check($sformatf("R4 tap code %0d", code), en[0], (k % n) == 0);
        end
    endtask

    task automatic t_free_run_R5();
        @(negedge clk) begin sel0 = 3'd2; sel1 = 3'd3; end
        pulse_clr();
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            check("R5 ch0 phase kept", en[0], (k % 8) == 0);
            case (k)
                5:  sel1 = 3'd0;
                13: sel1 = 3'd7;
                22: sel1 = 3'd1;
                30: sel1 = 3'd5;
                default: ;
            endcase
        end
    endtask

    task automatic t_shared_clear_R6();
        @(negedge clk) begin sel0 = 3'd2; sel1 = 3'd4; end
        repeat (37) @(negedge clk);
        pulse_clr();
        for (int k = 1; k <= 520; k++) begin
            @(negedge clk);
            check("R6 ch0 after clear", en[0], (k % 8) == 0);
            check("R6 R10 ch1 after clear", en[1], (k % 256) == 0);
        end
    endtask

    task automatic t_first_strobe_R7(input int wait_cyc);
        int k;
        @(negedge clk) begin sel0 = 3'd0; sel1 = 3'd0; end
        repeat (wait_cyc) @(negedge clk);
        sel0 = 3'd3;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!en[0] && k <= 66);
        check($sformatf("R7 first strobe within 65 (took %0d)", k), k >= 1 && k <= 65, 1'b1);
    endtask

    task automatic t_ext_fall_R8();
        @(negedge clk) begin sel0 = 3'd6; sel1 = 3'd0; end
        @(negedge clk) fall[0] = 1'b1;
        @(negedge clk);
        check("R8 fall passes", en[0], 1'b1);
        fall[0] = 1'b0; rise[0] = 1'b1;
        @(negedge clk);
        check("R8 rise ignored", en[0], 1'b0);
        rise[0] = 1'b0;
        @(negedge clk);
        check("R8 idle", en[0], 1'b0);
    endtask

    task automatic t_ext_rise_R9();
        @(negedge clk) begin sel0 = 3'd0; sel1 = 3'd7; end
        @(negedge clk) rise[1] = 1'b1;
        @(negedge clk);
        check("R9 rise passes", en[1], 1'b1);
        check("R9 R10 ch0 unaffected", en[0], 1'b0);
        rise[1] = 1'b0; fall[1] = 1'b1;
        @(negedge clk);
        check("R9 fall ignored", en[1], 1'b0);
        fall[1] = 1'b0;
        @(negedge clk);
        check("R9 idle", en[1], 1'b0);
    endtask

    initial begin
        t_reset_R1();
        t_stop_sysclk_R2_R3();
        t_tap_R4(3'd2, 8);
        t_tap_R4(3'd3, 64);
        t_tap_R4(3'd4, 256);
        t_tap_R4(3'd5, 1024);
        t_free_run_R5();
        t_shared_clear_R6();
        t_first_strobe_R7(3);
        t_first_strobe_R7(17);
        t_first_strobe_R7(40);
        t_ext_fall_R8();
        t_ext_rise_R9();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule